// File: doc/BRIEF.md
# Per-Port Link Hold-Off Controller

This block gates the link of each port of an eight-port Ethernet PHY during bring-up. While hardware reset is asserted it captures a strap input. When the strap is high, every port leaves reset with its link disabled, so management software can configure each port before traffic starts. Software then releases one port at a time by writing its control word with the power-down bit cleared.

Software can hold a port again at any time. It does this either by setting the power-down bit, or by issuing a soft reset through the control-register reset bit. A soft reset restores the power-down bit to the strap value captured at the last hardware reset. A management-disable input forces every link enabled and blocks register writes. This suits unmanaged boards where no software would ever release the ports.

Top module: `link_holdoff_ctrl`

## Requirements
- R1: On the first clock edge after `rst_ni` is released, every bit of `pd_o` takes the value `strap_i` had at the last clock edge during reset. A high strap therefore leaves every port held, and a low strap leaves every port released.
- R2: While `rst_ni` is low, every bit of `pd_o` reads 1.
- R3: A write with bit 15 = 0 and bit 11 = 0 clears `pd_o` for the addressed port only, one clock after the write.
- R4: A write with bit 15 = 0 and bit 11 = 1 sets `pd_o` for the addressed port, whatever the strap value.
- R5: A write with bit 15 = 1 is a soft reset. The addressed port's `pd_o` becomes the captured strap value, and bit 11 of the same write is ignored.
- R6: The captured strap value changes only during hardware reset. Changes on `strap_i` afterwards have no effect, including on later soft resets.
- R7: `link_en_o[p]` equals the inverse of `pd_o[p]` ORed with `mgmt_dis_i`.
- R8: While `mgmt_dis_i` is high, writes are ignored and `pd_o` does not change.
- R9: Bits other than 11 and 15 of `wr_data_i` have no effect on `pd_o` or `link_en_o`.
- R10: `wr_addr_i` (3 bits, value p) selects port p; no other port changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; must run while reset is held |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| strap_i | input | 1 | Hold-off strap, captured during reset |
| mgmt_dis_i | input | 1 | Management disable: forces links on, blocks writes |
| wr_en_i | input | 1 | Control-word write strobe |
| wr_addr_i | input | 3 | Port address of the write |
| wr_data_i | input | 16 | Control word; bit 15 soft reset, bit 11 power-down |
| link_en_o | output | 8 | Per-port link enable |
| pd_o | output | 8 | Per-port power-down (hold-off) readback |

## Verification
The assertions assume that `strap_i` is driven to a known level for at least one clock edge while `rst_ni` is low. They also assume that the write strobe, address and data are stable across the rising edge that samples them. The bench holds reset for several cycles with the strap already set. It changes every input only on falling edges and samples outputs on falling edges. It also issues writes only after the first post-reset edge, so the capture of the strap never competes with a write.

// File: rtl/lho_pkg.sv
package lho_pkg;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned PD_POS   = 11;
  localparam int unsigned SRST_POS = 15;
endpackage

// File: rtl/lho_strap_sampler.sv
module lho_strap_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic strap_o,
  output logic init_o
);
  logic strap_q;
  logic init_q;

  // captured on every edge while reset is held, frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) strap_q <= strap_i;
  end

  // one-cycle pulse after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b1;
    else         init_q <= 1'b0;
  end

  assign strap_o = strap_q;
  assign init_o  = init_q;

  a_r6_strap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |-> $stable(strap_q));
endmodule

// File: rtl/lho_wr_decode.sv
module lho_wr_decode #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic              wr_en_i,
  input  logic              mgmt_dis_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_PORTS-1:0] sel_o
);
  logic wr_ok;
  assign wr_ok = wr_en_i & ~mgmt_dis_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
    assign sel_o[p] = wr_ok & (addr_i == ADDR_W'(p));
  end

  always_comb begin
    a_r10_one_port: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/lho_port_ctl.sv
module lho_port_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic strap_i,
  input  logic wr_i,
  input  logic srst_i,
  input  logic pd_i,
  output logic hold_o
);
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= 1'b1;
    else if (init_i) hold_q <= strap_i;
    else if (wr_i)   hold_q <= srst_i ? strap_i : pd_i;
  end

  assign hold_o = hold_q;

  a_r5_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && srst_i && !init_i |=> hold_q == strap_i);
  a_r4_set_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !srst_i && pd_i && !init_i |=> hold_q);
  a_r3_clear_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !srst_i && !pd_i && !init_i |=> !hold_q);
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) && !$past(init_i) |-> $stable(hold_q));
endmodule

// File: rtl/link_holdoff_ctrl.sv
module link_holdoff_ctrl
  import lho_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned ADDR_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strap_i,
  input  logic                 mgmt_dis_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [CTRL_W-1:0]    wr_data_i,
  output logic [NUM_PORTS-1:0] link_en_o,
  output logic [NUM_PORTS-1:0] pd_o
);
  logic                 strap_q;
  logic                 init_q;
  logic [NUM_PORTS-1:0] sel;
  logic [NUM_PORTS-1:0] hold;
  logic                 unused_ctrl_bits;

  // remaining control bits are accepted but do not affect this block
  assign unused_ctrl_bits = ^{wr_data_i[SRST_POS-1:PD_POS+1], wr_data_i[PD_POS-1:0]};

  lho_strap_sampler i_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (strap_i),
    .strap_o (strap_q),
    .init_o  (init_q)
  );

  lho_wr_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) i_dec (
    .wr_en_i    (wr_en_i),
    .mgmt_dis_i (mgmt_dis_i),
    .addr_i     (wr_addr_i),
    .sel_o      (sel)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    lho_port_ctl i_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .init_i  (init_q),
      .strap_i (strap_q),
      .wr_i    (sel[p]),
      .srst_i  (wr_data_i[SRST_POS]),
      .pd_i    (wr_data_i[PD_POS]),
      .hold_o  (hold[p])
    );
  end

  assign pd_o      = hold;
  assign link_en_o = ~hold | {NUM_PORTS{mgmt_dis_i}};

  a_r8_mgmt_blocks_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_dis_i && !init_q |=> $stable(pd_o));
  a_r1_init_from_strap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |=> pd_o == {NUM_PORTS{strap_q}});
endmodule

// File: tb/test_link_holdoff_ctrl.sv
`timescale 1ns/1ps
module test_link_holdoff_ctrl;
  localparam int NP = 8;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b1;
  logic        mdis = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] data = '0;
  logic [NP-1:0] link_en;
  logic [NP-1:0] pd;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  link_holdoff_ctrl i_link_holdoff_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .mgmt_dis_i(mdis),
    .wr_en_i(wr), .wr_addr_i(addr), .wr_data_i(data),
    .link_en_o(link_en), .pd_o(pd)
  );

  // {wr, mdis, addr, data, exp_pd, exp_link}; strap high at reset
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 16'h0000, 8'hFE, 8'h01},  // R3
    {1'b1, 1'b0, 3'd5, 16'h0000, 8'hDE, 8'h21},  // R10
    {1'b1, 1'b0, 3'd0, 16'h0800, 8'hDF, 8'h20},  // R4
    {1'b1, 1'b0, 3'd5, 16'h8000, 8'hFF, 8'h00},  // R5
    {1'b1, 1'b0, 3'd3, 16'h77FF, 8'hF7, 8'h08},  // R9
    {1'b1, 1'b0, 3'd3, 16'h0000, 8'hF7, 8'h08},  // R9
    {1'b1, 1'b1, 3'd3, 16'h0800, 8'hF7, 8'hFF},  // R8
    {1'b0, 1'b1, 3'd0, 16'h0000, 8'hF7, 8'hFF},  // R7
    {1'b1, 1'b0, 3'd3, 16'h8800, 8'hFF, 8'h00},  // R5
    {1'b1, 1'b0, 3'd2, 16'h0000, 8'hFB, 8'h04}   // R3
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 9:    return "R3";
      1:       return "R10";
      2:       return "R4";
      3, 8:    return "R5";
      4, 5:    return "R9";
      6:       return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [NP-1:0] act, logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic w, logic m, logic [2:0] a, logic [15:0] d);
    wr = w; mdis = m; addr = a; data = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_reset(logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; mdis = 1'b0; wr = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 pd during reset", pd, '1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    check("R1 pd strap high", pd, 8'hFF);
    check("R1 link strap high", link_en, 8'h00);
    strap = 1'b0;  // R6: later strap change must not matter

    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      v = VEC[i];
      step(v[36], v[35], v[34:32], v[31:16]);
      check({vec_tag(i), " pd"}, pd, v[15:8]);
      check({vec_tag(i), " link"}, link_en, v[7:0]);
    end

    // R6: soft reset still uses strap captured high
    step(1'b1, 1'b0, 3'd2, 16'h8000);
    check("R6 soft reset keeps captured strap", pd, 8'hFF);

    do_reset(1'b0);
    check("R1 pd strap low", pd, 8'h00);
    check("R7 link strap low", link_en, 8'hFF);
    step(1'b1, 1'b0, 3'd4, 16'h0800);
    check("R4 set pd strap low", pd, 8'h10);
    check("R7 link after set", link_en, 8'hEF);
    strap = 1'b1;
    step(1'b1, 1'b0, 3'd4, 16'h8800);
    check("R5 R6 soft reset strap low", pd, 8'h00);
    step(1'b1, 1'b0, 3'd7, 16'h0800);
    check("R10 top address", pd, 8'h80);
    mdis = 1'b1;
    @(negedge clk);
    check("R7 mgmt forces link", link_en, 8'hFF);
    step(1'b1, 1'b1, 3'd7, 16'h0000);
    check("R8 write ignored", pd, 8'h80);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule